// File: doc/BRIEF.md
# Four-Buffer Synchronous Slave FIFO Port

This block lets an external processor or FPGA move 32-bit words into and out of four internal buffers over a synchronous parallel port. The master picks a buffer with a 2-bit address, selects the port with an active-low chip select, and uses active-low write, read and output-enable strobes. Everything happens on the rising clock edge. The bidirectional data bus is split into an input path (`dq_i`), an output path (`dq_o`) and an output-enable (`dq_oe`) for a pad cell outside the block.

Each buffer holds a word only after it has been marked as part of a finished packet. The master writes a run of words and then pulses the active-low packet-end input. That commits the whole current fill of the addressed buffer as one packet, even when the packet is shorter than the buffer. Only committed words can be read back. Two flags describe the addressed buffer: `flag_a` reports that it is full, and `flag_b` reports that its committed fill has reached a watermark.

A small bus-phase state machine classifies every clock into one of four states: `PH_IDLE`, `PH_WRITE`, `PH_READ` and `PH_CLASH`.
- A selected write strobe alone enters `PH_WRITE`.
- A selected read strobe alone enters `PH_READ`.
- Both strobes together enter `PH_CLASH`.
- Anything else returns to `PH_IDLE`.

Any state can move to any other on the next clock. Writes and reads are issued only in the write and read states.

Top module: `slave_fifo_port`

## Requirements
- R1: A word on `dq_i` is stored in the buffer chosen by `addr` at a rising edge where `cs_n`=0, `wr_n`=0 and `rd_n`=1. Each buffer keeps its words in write order, separate from the other buffers.
- R2: While `cs_n`=0 and `oe_n`=0, `dq_o` shows the oldest committed word of the addressed buffer, or 0 if none is committed. A rising edge with `cs_n`=0, `rd_n`=0 and `wr_n`=1 removes that word. A read of a buffer with no committed word changes nothing.
- R3: Written words cannot be read until a rising edge with `cs_n`=0 and `pkt_end_n`=0. That edge commits every word in the addressed buffer, including a word written on the same edge.
- R4: `flag_a` is 1 exactly when the addressed buffer holds DEPTH (default 8) words, committed or not. A write to a full buffer is dropped.
- R5: `flag_b` is 1 exactly when the addressed buffer holds at least WMARK (default 4) committed words.
- R6: `dq_oe` is 1 exactly when `cs_n`=0 and `oe_n`=0. While `dq_oe` is 0, `dq_o` is 0.
- R7: While `cs_n`=1, the write, read and packet-end strobes have no effect.
- R8: An edge with `cs_n`=0 and both `wr_n` and `rd_n` low neither writes nor reads.
- R9: The flags follow `addr` with no clock delay, and they show the effect of an edge in the cycle right after it.
- R10: After reset, all buffers are empty and both flags are 0 for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| oe_n | input | 1 | Output enable, active low |
| pkt_end_n | input | 1 | Packet-end strobe, active low |
| addr | input | 2 | Buffer select |
| dq_i | input | 32 | Data from master |
| dq_o | output | 32 | Data to master |
| dq_oe | output | 1 | Data bus drive enable |
| flag_a | output | 1 | Addressed buffer full |
| flag_b | output | 1 | Addressed buffer committed fill at or above watermark |

## Verification
Read data is available first-word-fall-through, so the word a read returns is already on `dq_o` during the cycle whose closing edge removes it. The monitor therefore compares `dq_o` at the falling edge within the read cycle. Writes, packet-end strobes and reads take effect at the rising edge that closes their cycle. Flags are decoded from registered counts, so each flag check looks at the falling edge of the cycle after the stimulus edge. The bench drives inputs one time unit after a rising edge and samples only at falling edges, which keeps every comparison one full register stage clear of the edge that changes it.

// File: rtl/slave_fifo_pkg.sv
package slave_fifo_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_CLASH = 2'd3
    } bus_phase_t;

endpackage

// File: rtl/sf_bus_ctrl.sv
module sf_bus_ctrl
    import slave_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       wr_n,
    input  logic       rd_n,
    input  logic       pkt_end_n,
    output logic       push_o,
    output logic       pop_o,
    output logic       commit_o,
    output bus_phase_t phase_o
);

    bus_phase_t phase_q;
    bus_phase_t phase_d;

    // next-state decode: every state may reach every other on the strobes
    always_comb begin
        phase_d = PH_IDLE;
        if (!cs_n) begin
            unique case ({wr_n, rd_n})
                2'b01:   phase_d = PH_WRITE;
                2'b10:   phase_d = PH_READ;
                2'b00:   phase_d = PH_CLASH;
                default: phase_d = PH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // outputs for the access happening in this cycle
    always_comb begin
        push_o   = 1'b0;
        pop_o    = 1'b0;
        commit_o = !cs_n && !pkt_end_n;
        unique case (phase_d)
            PH_WRITE: push_o = 1'b1;
            PH_READ:  pop_o  = 1'b1;
            PH_CLASH: begin
                push_o = 1'b0;
                pop_o  = 1'b0;
            end
            default: ;
        endcase
    end

    assign phase_o = phase_q;

    a_r7_deselect_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!push_o && !pop_o && !commit_o));

    a_r8_clash_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !rd_n) |-> (!push_o && !pop_o));

    a_r8_clash_state: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !wr_n && !rd_n) |=> (phase_o == PH_CLASH));

endmodule

// File: rtl/sf_buffer.sv
module sf_buffer #(
    parameter int W     = 32,
    parameter int DEPTH = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push_i,
    input  logic [W-1:0]               wdata_i,
    input  logic                       pop_i,
    input  logic                       commit_i,
    output logic [W-1:0]               head_o,
    output logic [$clog2(DEPTH+1)-1:0] count_o,
    output logic [$clog2(DEPTH+1)-1:0] ready_o
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_P = PW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wptr_q, rptr_q;
    logic [CW-1:0] count_q, ready_q, count_d, ready_d;
    logic          push_ok, pop_ok;

    assign push_ok = push_i && (count_q != FULL_C);
    assign pop_ok  = pop_i && (ready_q != '0);

    always_comb begin
        count_d = count_q;
        unique case ({push_ok, pop_ok})
            2'b10:   count_d = count_q + CW'(1);
            2'b01:   count_d = count_q - CW'(1);
            default: count_d = count_q;
        endcase
        ready_d = pop_ok ? (ready_q - CW'(1)) : ready_q;
        if (commit_i) ready_d = count_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q  <= '0;
            rptr_q  <= '0;
            count_q <= '0;
            ready_q <= '0;
        end else begin
            count_q <= count_d;
            ready_q <= ready_d;
            if (push_ok) wptr_q <= (wptr_q == LAST_P) ? '0 : wptr_q + PW'(1);
            if (pop_ok)  rptr_q <= (rptr_q == LAST_P) ? '0 : rptr_q + PW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr_q] <= wdata_i;
    end

    assign head_o  = (ready_q != '0) ? mem[rptr_q] : '0;
    assign count_o = count_q;
    assign ready_o = ready_q;

    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_q <= FULL_C);

    a_r4_full_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && count_q == FULL_C) |=> (count_q == FULL_C));

    a_r3_ready_within_fill: assert property (@(posedge clk) disable iff (!rst_n)
        ready_q <= count_q);

    a_r3_commit_takes_all: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_i && !pop_i) |=> (ready_q == count_q));

    a_r2_empty_pop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && ready_q == '0) |=> $stable(count_q));

endmodule

// File: rtl/sf_flags.sv
module sf_flags #(
    parameter int DEPTH = 8,
    parameter int WMARK = 4
) (
    input  logic [$clog2(DEPTH+1)-1:0] count_i,
    input  logic [$clog2(DEPTH+1)-1:0] ready_i,
    output logic                       full_o,
    output logic                       wmark_o
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);
    localparam logic [CW-1:0] WM_C   = CW'(WMARK);

    assign full_o  = (count_i == FULL_C);
    assign wmark_o = (ready_i >= WM_C);

endmodule

// File: rtl/slave_fifo_port.sv
module slave_fifo_port #(
    parameter int W     = 32,
    parameter int NBUF  = 4,
    parameter int DEPTH = 8,
    parameter int WMARK = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cs_n,
    input  logic                     wr_n,
    input  logic                     rd_n,
    input  logic                     oe_n,
    input  logic                     pkt_end_n,
    input  logic [$clog2(NBUF)-1:0]  addr,
    input  logic [W-1:0]             dq_i,
    output logic [W-1:0]             dq_o,
    output logic                     dq_oe,
    output logic                     flag_a,
    output logic                     flag_b
);
    import slave_fifo_pkg::*;

    localparam int CW = $clog2(DEPTH + 1);

    logic       push, pop, commit;
    bus_phase_t phase;

    logic [W-1:0]  head_a  [NBUF];
    logic [CW-1:0] count_a [NBUF];
    logic [CW-1:0] ready_a [NBUF];

    sf_bus_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .wr_n     (wr_n),
        .rd_n     (rd_n),
        .pkt_end_n(pkt_end_n),
        .push_o   (push),
        .pop_o    (pop),
        .commit_o (commit),
        .phase_o  (phase)
    );

    for (genvar gi = 0; gi < NBUF; gi++) begin : g_buf
        logic hit;
        assign hit = (addr == ($clog2(NBUF))'(gi));
        sf_buffer #(.W(W), .DEPTH(DEPTH)) u_buf (
            .clk     (clk),
            .rst_n   (rst_n),
            .push_i  (push && hit),
            .wdata_i (dq_i),
            .pop_i   (pop && hit),
            .commit_i(commit && hit),
            .head_o  (head_a[gi]),
            .count_o (count_a[gi]),
            .ready_o (ready_a[gi])
        );
    end

    sf_flags #(.DEPTH(DEPTH), .WMARK(WMARK)) u_flags (
        .count_i(count_a[addr]),
        .ready_i(ready_a[addr]),
        .full_o (flag_a),
        .wmark_o(flag_b)
    );

    assign dq_oe = !cs_n && !oe_n;
    assign dq_o  = dq_oe ? head_a[addr] : '0;

    a_r6_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !dq_oe |-> (dq_o == '0));

    a_r7_idle_phase: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (phase == PH_IDLE));

endmodule

// File: tb/sim_slave_fifo_port.sv
module sim_slave_fifo_port;

    localparam int PERIOD = 10;
    localparam int DEPTH  = 8;
    localparam int WMARK  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, oe_n = 1'b1, pkt_end_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [31:0] dq_i = '0;
    logic [31:0] dq_o;
    logic        dq_oe, flag_a, flag_b;

    int vectors = 0;
    int misses  = 0;

    // reference model per buffer
    logic [31:0] mdat [4][16];
    int mhead [4];
    int mcnt  [4];
    int mrdy  [4];
    logic [31:0] exp_q [$];

    always #(PERIOD/2) clk = ~clk;

    slave_fifo_port u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n),
        .oe_n(oe_n), .pkt_end_n(pkt_end_n), .addr(addr), .dq_i(dq_i),
        .dq_o(dq_o), .dq_oe(dq_oe), .flag_a(flag_a), .flag_b(flag_b)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go_idle();
        cs_n = 1'b1; wr_n = 1'b1; rd_n = 1'b1; oe_n = 1'b1; pkt_end_n = 1'b1;
    endtask

    task automatic step();
        @(posedge clk); #1;
        go_idle();
    endtask

    task automatic wr(input int b, input logic [31:0] d, input bit pe);
        @(posedge clk); #1;
        go_idle();
        addr = 2'(b); cs_n = 1'b0; wr_n = 1'b0; dq_i = d; pkt_end_n = !pe;
        if (mcnt[b] < DEPTH) begin
            mdat[b][(mhead[b] + mcnt[b]) % 16] = d;
            mcnt[b]++;
        end
        if (pe) mrdy[b] = mcnt[b];
    endtask

    task automatic pend(input int b);
        @(posedge clk); #1;
        go_idle();
        addr = 2'(b); cs_n = 1'b0; pkt_end_n = 1'b0;
        mrdy[b] = mcnt[b];
    endtask

    task automatic rd(input int b);
        @(posedge clk); #1;
        go_idle();
        addr = 2'(b); cs_n = 1'b0; rd_n = 1'b0; oe_n = 1'b0;
        if (mrdy[b] > 0) begin
            exp_q.push_back(mdat[b][mhead[b]]);
            mhead[b] = (mhead[b] + 1) % 16;
            mcnt[b]--; mrdy[b]--;
        end else begin
            exp_q.push_back(32'h0);
        end
    endtask

    // R9: flags read at the falling edge of the cycle after the last edge
    task automatic flags(input int b, input string req);
        @(posedge clk); #1;
        go_idle();
        addr = 2'(b);
        @(negedge clk);
        check({req, " flag_a"}, {31'b0, flag_a}, {31'b0, mcnt[b] == DEPTH});
        check({req, " flag_b"}, {31'b0, flag_b}, {31'b0, mrdy[b] >= WMARK});
    endtask

    // monitor: the word shown during a read cycle is the one it consumes
    always @(negedge clk) begin
        if (rst_n && !cs_n && !rd_n && wr_n && !oe_n) begin
            if (exp_q.size() == 0) begin
                misses++;
                $display("FAIL R2: actual %h expected none queued", dq_o);
            end else begin
                check("R2 read data", dq_o, exp_q.pop_front());
            end
        end
    end

    initial begin
        #(PERIOD * 100000);
        misses++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            mhead[i] = 0; mcnt[i] = 0; mrdy[i] = 0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        for (int i = 0; i < 4; i++) flags(i, "R10");
        @(negedge clk);
        check("R10 dq_oe", {31'b0, dq_oe}, 32'h0);

        // R1/R3: uncommitted words are not readable
        for (int i = 0; i < 3; i++) wr(0, 32'hA000_0000 + i, 1'b0);
        rd(0);
        flags(0, "R3 pending");
        pend(0);
        for (int i = 0; i < 3; i++) rd(0);
        rd(0);

        // R3: word on the packet-end edge is committed
        wr(1, 32'hB000_0001, 1'b0);
        wr(1, 32'hB000_0002, 1'b1);
        rd(1); rd(1); rd(1);

        // R5 watermark
        for (int i = 0; i < 4; i++) wr(2, 32'hC000_0000 + i, 1'b0);
        flags(2, "R5 uncommitted");
        pend(2);
        flags(2, "R5 at mark");
        rd(2);
        flags(2, "R5 below mark");

        // R4 full and dropped write
        for (int i = 0; i < DEPTH; i++) wr(3, 32'hD000_0000 + i, 1'b0);
        flags(3, "R4 full");
        wr(3, 32'hDEAD_BEEF, 1'b0);
        pend(3);
        flags(3, "R4 full committed");
        for (int i = 0; i < DEPTH + 1; i++) rd(3);
        flags(3, "R4 drained");

        // R8 clash: buffer 2 holds 3 committed words
        @(posedge clk); #1;
        go_idle();
        addr = 2'd2; cs_n = 1'b0; wr_n = 1'b0; rd_n = 1'b0; dq_i = 32'h5555_5555;
        flags(2, "R8 clash");
        for (int i = 0; i < 4; i++) rd(2);

        // R7 deselected strobes ignored
        @(posedge clk); #1;
        go_idle();
        addr = 2'd0; wr_n = 1'b0; pkt_end_n = 1'b0; dq_i = 32'h7777_7777;
        rd(0);
        wr(1, 32'hE000_0001, 1'b1);
        @(posedge clk); #1;
        go_idle();
        addr = 2'd1; rd_n = 1'b0;
        rd(1);

        // R6 output enable, peek without read keeps data
        wr(0, 32'hF000_0001, 1'b1);
        @(posedge clk); #1;
        go_idle();
        addr = 2'd0; cs_n = 1'b0; oe_n = 1'b1;
        @(negedge clk);
        check("R6 oe high dq_oe", {31'b0, dq_oe}, 32'h0);
        check("R6 oe high dq_o", dq_o, 32'h0);
        oe_n = 1'b0;
        #1;
        check("R6 oe low dq_oe", {31'b0, dq_oe}, 32'h1);
        check("R6 peek head", dq_o, 32'hF000_0001);
        rd(0);

        // R1/R9 interleaved buffers, flags follow addr
        for (int i = 0; i < 5; i++) begin
            wr(0, 32'h1000_0000 + i, 1'b0);
            wr(1, 32'h2000_0000 + i, 1'b0);
        end
        pend(0);
        flags(0, "R9 addr 0");
        flags(1, "R9 addr 1");
        pend(1);
        flags(1, "R9 addr 1 committed");
        for (int i = 0; i < 5; i++) rd(1);
        for (int i = 0; i < 5; i++) rd(0);
        step();
        step();
        check("R2 scoreboard drained", exp_q.size(), 32'h0);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule